// File: doc/BRIEF.md
# Parallel Self-Synchronizing Scrambler

This block is a multiplicative scrambler that takes a word of `WIDTH` data bits per clock. It returns the same `WIDTH` scrambled bits that a one-bit-per-clock scrambler would produce over `WIDTH` bit times. Each scrambled bit is the XOR of its data bit and two earlier scrambled bits. Those earlier bits sit `TAP_NEAR` and `TAP_FAR` bit times back. Bit 0 of a word is the earliest bit in serial order, on both the input and the output.

The serial recurrence is unrolled across the word. A term that falls inside the current word comes straight from the combinational result for that bit. A term that falls before the word comes from a history register. That register holds the last `TAP_FAR` scrambled bits and advances only on accepted words.

The default is the polynomial x^3 + x + 1 on a 4-bit word (taps 2 and 3). The same RTL builds x^58 + x^19 + 1 on a 64-bit word (taps 39 and 58).

Top module: `par_scrambler`

## Requirements
- R1: With bit 0 as the earliest bit, every output bit obeys S(t) = D(t) XOR S(t-TAP_NEAR) XOR S(t-TAP_FAR). This holds inside a word and across word boundaries. The default taps are 2 and 3.
- R2: A word presented with `inValid` high at clock edge n appears on `outData` after edge n. Back-to-back words are accepted on every clock with no stall.
- R3: `outValid` equals the value `inValid` had at the previous clock edge.
- R4: A cycle with `inValid` low leaves the history unchanged, whatever `inData` holds. The scrambled sequence therefore continues as if the idle cycle never happened.
- R5: While no word is accepted, `outData` keeps its last value.
- R6: A synchronous `rst` clears the history and `outData` to zero and drives `outValid` low. The first word after reset is scrambled against an all-zero history.
- R7: With WIDTH=64, TAP_NEAR=39 and TAP_FAR=58 (x^58 + x^19 + 1), the block obeys R1 to R5 with those taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Input word is valid this cycle |
| inData | input | WIDTH | Data word; bit 0 is earliest in serial order |
| outValid | output | 1 | Scrambled word valid |
| outData | output | WIDTH | Scrambled word; bit 0 is earliest |

## Verification
A single-one impulse after reset shows where each tap lands. It separates terms taken from the same word from terms taken from history, and in the 64-bit build it exposes both the 39 and 58 positions. All-zero, all-one and alternating words, followed by random runs, check that the feedback is carried correctly across word seams. Idle cycles carrying random data show whether the history or the output moves when it should hold. A reset in the middle of a run checks that the sequence restarts from an all-zero history.

// File: rtl/scr_pkg.sv
package scr_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // accept the current word
    logic clear;     // synchronous clear of all state
  } scr_strobe_t;
endpackage

// File: rtl/scr_ctrl.sv
module scr_ctrl
  import scr_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output scr_strobe_t strobe,
  output logic        outValid
);
  always_comb begin
    strobe.clear   = rst;
    strobe.advance = inValid & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end

  // R3: valid out tracks valid in with one cycle of latency
  assert_valid_rise_R3: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  assert_valid_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
endmodule

// File: rtl/scr_datapath.sv
module scr_datapath
  import scr_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int TAP_NEAR = 2,
  parameter int TAP_FAR  = 3
) (
  input  logic             clk,
  input  scr_strobe_t      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] scrOut
);
  localparam int HIST  = TAP_FAR;          // deepest tap sets history depth
  localparam int CHAIN = HIST + WIDTH;     // history followed by current word

  // histQ[j] holds the scrambled bit emitted HIST-j bit times before the word
  logic [HIST-1:0]  histQ;
  logic [CHAIN-1:0] chain;
  logic [WIDTH-1:0] scrNext;
  logic [HIST-1:0]  histNext;

  // unrolled recurrence: later bits reuse bits of the same word
  always_comb begin
    chain = '0;
    chain[HIST-1:0] = histQ;
    for (int i = 0; i < WIDTH; i++) begin
      chain[HIST+i] = dataIn[i] ^ chain[HIST+i-TAP_NEAR] ^ chain[HIST+i-TAP_FAR];
    end
  end

  assign scrNext  = chain[CHAIN-1 -: WIDTH];
  assign histNext = chain[CHAIN-1 -: HIST];

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      histQ  <= '0;
      scrOut <= '0;
    end else if (strobe.advance) begin
      histQ  <= histNext;
      scrOut <= scrNext;
    end
  end

  // R4: idle cycles leave the history alone
  assert_hist_hold_R4: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.advance |=> $stable(histQ));

  // R5: idle cycles leave the output word alone
  assert_out_hold_R5: assert property (@(posedge clk) disable iff (strobe.clear)
    !strobe.advance |=> $stable(scrOut));

  // R1: first bit of a word uses only the stored history
  assert_seam_R1: assert property (@(posedge clk) disable iff (strobe.clear)
    strobe.advance |=> scrOut[0] ==
      ($past(dataIn[0]) ^ $past(histQ[HIST-TAP_NEAR]) ^ $past(histQ[0])));

  // R1: bits whose both taps fall inside the word
  for (genvar gi = TAP_FAR; gi < WIDTH; gi++) begin : gInWord
    assert_inword_R1: assert property (@(posedge clk) disable iff (strobe.clear)
      strobe.advance |=> scrOut[gi] ==
        ($past(dataIn[gi]) ^ scrOut[gi-TAP_NEAR] ^ scrOut[gi-TAP_FAR]));
  end
endmodule

// File: rtl/par_scrambler.sv
module par_scrambler
  import scr_pkg::*;
#(
  parameter int WIDTH    = 4,
  parameter int TAP_NEAR = 2,
  parameter int TAP_FAR  = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic [WIDTH-1:0] inData,
  output logic             outValid,
  output logic [WIDTH-1:0] outData
);
  scr_strobe_t strobe;

  scr_ctrl uCtrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  scr_datapath #(
    .WIDTH    (WIDTH),
    .TAP_NEAR (TAP_NEAR),
    .TAP_FAR  (TAP_FAR)
  ) uData (
    .clk    (clk),
    .strobe (strobe),
    .dataIn (inData),
    .scrOut (outData)
  );
endmodule

// File: tb/sim_par_scrambler.sv
module sim_par_scrambler;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 4,  NA = 2,  FA = 3;
  localparam int WB = 64, NB = 39, FB = 58;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vA = 1'b0, vB = 1'b0;
  logic [WA-1:0] dA = '0;
  logic [WB-1:0] dB = '0;
  logic ovA, ovB;
  logic [WA-1:0] oA;
  logic [WB-1:0] oB;

  int checks = 0, fails = 0;
  string tagA = "R6", tagB = "R7";
  logic [WA-1:0] qA[$];
  logic [WB-1:0] qB[$];
  logic [63:0] refHA = '0, refHB = '0;  // bit k = scrambled bit k+1 steps back
  logic [WA-1:0] lastA = '0;
  logic [WB-1:0] lastB = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par_scrambler u0 (.clk(clk), .rst(rst), .inValid(vA), .inData(dA),
                    .outValid(ovA), .outData(oA));

  par_scrambler #(.WIDTH(WB), .TAP_NEAR(NB), .TAP_FAR(FB)) u1 (
    .clk(clk), .rst(rst), .inValid(vB), .inData(dB),
    .outValid(ovB), .outData(oB));

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // bit-serial reference recurrence, w steps
  task automatic refWord(input logic [63:0] d, input int w, input int n, input int f,
                         inout logic [63:0] h, output logic [63:0] r);
    logic s;
    r = '0;
    for (int i = 0; i < w; i++) begin
      s = d[i] ^ h[n-1] ^ h[f-1];
      r[i] = s;
      h = {h[62:0], s};
    end
  endtask

  task automatic driveA(input logic [WA-1:0] d, input bit v);
    logic [63:0] r;
    @(negedge clk);
    vA = v; dA = d;
    if (v) begin
      refWord({60'b0, d}, WA, NA, FA, refHA, r);
      qA.push_back(r[WA-1:0]);
    end
  endtask

  task automatic driveB(input logic [WB-1:0] d, input bit v);
    logic [63:0] r;
    @(negedge clk);
    vB = v; dB = d;
    if (v) begin
      refWord(d, WB, NB, FB, refHB, r);
      qB.push_back(r);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; vA = 1'b0; vB = 1'b0;
    refHA = '0; refHB = '0;
    qA.delete(); qB.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // scoreboard monitor, instance u0
  always @(posedge clk) begin
    logic vS, rS;
    logic [WA-1:0] e;
    vS = vA; rS = rst;
    #1;
    if (rS) begin
      check(ovA == 1'b0 && oA == '0, "R6", "A reset state", {59'b0, ovA, oA}, 64'h0);
    end else begin
      check(ovA == vS, "R3", "A outValid", {63'b0, ovA}, {63'b0, vS});
      if (ovA) begin
        if (qA.size() == 0) check(1'b0, "R2", "A unexpected word", {60'b0, oA}, 64'h0);
        else begin
          e = qA.pop_front();
          check(oA == e, tagA, "A word", {60'b0, oA}, {60'b0, e});
        end
      end else begin
        check(oA == lastA, "R5", "A hold", {60'b0, oA}, {60'b0, lastA});
      end
    end
    lastA = oA;
  end

  // scoreboard monitor, instance u1
  always @(posedge clk) begin
    logic vS, rS;
    logic [WB-1:0] e;
    vS = vB; rS = rst;
    #1;
    if (rS) begin
      check(ovB == 1'b0 && oB == '0, "R6", "B reset state", oB, 64'h0);
    end else begin
      check(ovB == vS, "R3", "B outValid", {63'b0, ovB}, {63'b0, vS});
      if (ovB) begin
        if (qB.size() == 0) check(1'b0, "R7", "B unexpected word", oB, 64'h0);
        else begin
          e = qB.pop_front();
          check(oB == e, tagB, "B word", oB, e);
        end
      end else begin
        check(oB == lastB, "R5", "B hold", oB, lastB);
      end
    end
    lastB = oB;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "WDOG", "watchdog expired", 64'h0, 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    doReset();
    // R6: first word after reset sees zero history; impulse shows taps
    tagA = "R6";
    driveA(4'b0001, 1'b1);
    tagA = "R1";
    driveA(4'b0000, 1'b1);
    driveA(4'b0000, 1'b1);
    driveA(4'b1111, 1'b1);
    driveA(4'b0101, 1'b1);
    driveA(4'b1010, 1'b1);
    driveA(4'b0000, 1'b1);
    // R2: long back-to-back random run
    tagA = "R2";
    for (int k = 0; k < 40; k++) driveA(4'($urandom), 1'b1);
    // R4: idle cycles carrying garbage between words
    tagA = "R4";
    for (int k = 0; k < 30; k++) begin
      driveA(4'($urandom), 1'b1);
      driveA(4'($urandom), 1'b0);
      if (k % 3 == 0) driveA(4'($urandom), 1'b0);
    end
    driveA(4'b0000, 1'b0);
    repeat (3) @(negedge clk);
    // R6: mid-run reset restarts from zero history
    doReset();
    tagA = "R6";
    driveA(4'b1000, 1'b1);
    driveA(4'b0000, 1'b1);
    driveA(4'b0000, 1'b1);
    driveA(4'b0000, 1'b0);
    repeat (3) @(negedge clk);

    // R7: 64-bit build with taps 39 and 58
    tagB = "R7";
    driveB(64'h1, 1'b1);
    driveB(64'h0, 1'b1);
    driveB(64'h0, 1'b1);
    driveB({64{1'b1}}, 1'b1);
    driveB(64'h5555_5555_5555_5555, 1'b1);
    for (int k = 0; k < 20; k++) driveB({$urandom, $urandom}, 1'b1);
    for (int k = 0; k < 10; k++) begin
      driveB({$urandom, $urandom}, 1'b0);
      driveB({$urandom, $urandom}, 1'b1);
    end
    driveB(64'h0, 1'b0);
    repeat (4) @(negedge clk);

    check(qA.size() == 0, "R2", "A words left", 64'(qA.size()), 64'h0);
    check(qB.size() == 0, "R7", "B words left", 64'(qB.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule